// File: doc/BRIEF.md
# Stalled Register Access Timeout Guard

This block sits between a host register bus and a set of buffer control registers. Each control register starts a background buffer transfer when the host writes its request bit. The register then stays busy until the transfer engine reports completion. If a host read or write reaches a busy register, the block does one of two things, chosen by a per-register enable. It can hold the bus with wait states until the transfer completes, with the wait bounded by a programmable down-counter. Or it can reject the access at once and raise an error flag.

In the default configuration there are two control registers. Index 0 is the outbound-view register and index 1 is the inbound-commit register. The host sees four word addresses: 0 and 1 are the control registers, 2 is the timeout reload register, and 3 is the configuration/status register. When a stalled access runs out of time it is cancelled. A cancelled read returns zero and a cancelled write changes nothing. The cancellation also sets a sticky status bit, which drives the service request output until software clears it. The transfer engines themselves are outside the block. They are represented by the start pulses the block drives and the done pulses it receives.

Top module: `regaccess_stall_guard`

## Requirements
- R1: An access to a register that is not busy completes in the cycle it is presented (`host_ready` high in that same cycle). A read returns the stored value and a write updates it.
- R2: A completed write to control register i with bit 0 (the request bit) set pulses `xfer_start[i]` in that cycle. Register i is then busy from the next cycle until the cycle `xfer_done[i]` is high.
- R3: If stalling is enabled for register i and an access reaches it while it is busy, `host_ready` stays low. The counter loads the reload value in the first cycle. When `xfer_done[i]` arrives k cycles after the access was presented, and k is no greater than reload+1, the access completes normally in that cycle.
- R4: If the transfer is still busy when the counter is at zero, the access is cancelled with `host_ready` high. This happens reload+1 cycles after the access was presented. A cancelled read returns 0 and a cancelled write leaves the register unchanged.
- R5: A timeout cancellation sets the sticky timeout bit (status bit 2) and `svc_req`. Both stay set through later accesses until the host writes 1 to status bit 2.
- R6: If stalling is disabled for register i and an access reaches it while it is busy, the access completes at once but is cancelled. The read data is 0, the register is unchanged, no transfer is started, and reject flag i is set (status bit 3 for register 0, bit 4 for register 1). The service request is not raised.
- R7: If `xfer_done` arrives in the same cycle as the counter reaching zero, the access completes normally and no timeout is recorded.
- R8: With a reload value of 0, a stalled access that is still busy is cancelled one cycle after it was presented.
- R9: After reset, the control registers, the reload register, the stall enables and all flags read 0, and `svc_req` is low.
- R10: Status register layout: bits 1:0 are the stall enables (bit 0 for register 0, bit 1 for register 1) and are read/write. Bits 4:2 are the timeout and reject flags and are cleared by writing 1. The reload register reads back the value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_valid | input | 1 | Access request, held until `host_ready` |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W (2) | Word address: 0..NUM_CTRL-1 control, then reload, then status |
| host_wdata | input | DATA_W (32) | Write data |
| host_rdata | output | DATA_W (32) | Read data, valid while `host_valid` and `host_ready` |
| host_ready | output | 1 | Access completes this cycle |
| xfer_done | input | NUM_CTRL (2) | Per-register transfer completion pulse |
| xfer_start | output | NUM_CTRL (2) | Per-register transfer start pulse |
| ctrl_q | output | NUM_CTRL*DATA_W (64) | Stored control register values |
| svc_req | output | 1 | Service request, follows the sticky timeout bit |

## Verification
`host_ready`, `host_rdata` and `xfer_start` are combinational on the presented access, so a free or rejected access is due in cycle 0. A stalled access is due in cycle k when the done pulse is raised k negative edges after presentation, or in cycle reload+1 on timeout. The bench counts the falling edges seen before `host_ready` and compares that count with the expected value. The sweep covers reload values 0 to 3 against done delays 1 to 5 for both registers, so the equal-cycle tie at k = reload+1 is included. Flags and `svc_req` are registered, so they are sampled through a status read on a later access.

// File: rtl/stall_guard_pkg.sv
package stall_guard_pkg;
   typedef enum logic {
      GS_IDLE = 1'b0,
      GS_WAIT = 1'b1
   } guard_state_e;
endpackage

// File: rtl/sg_timer.sv
// Reloadable down-counter that bounds one stalled access.
module sg_timer #(
   parameter int TMO_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             dec,
   input  logic [TMO_W-1:0] reload,
   output logic             zero
);
   logic [TMO_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (load) cnt_q <= reload;
      else if (dec)  cnt_q <= cnt_q - TMO_W'(1);
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/sg_pending.sv
// Tracks one background transfer from start to done; a new start beats done.
module sg_pending (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic done,
   output logic busy
);
   logic pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pend_q <= 1'b0;
      else if (start) pend_q <= 1'b1;
      else if (done)  pend_q <= 1'b0;
   end

   // the completing cycle already counts as free
   assign busy = pend_q & ~done;
endmodule

// File: rtl/sg_w1c_flag.sv
// Sticky flag: set has priority over a write-one clear.
module sg_w1c_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end
endmodule

// File: rtl/regaccess_stall_guard.sv
module regaccess_stall_guard
   import stall_guard_pkg::*;
#(
   parameter int NUM_CTRL = 2,
   parameter int DATA_W   = 32,
   parameter int TMO_W    = 32,
   parameter int REQ_BIT  = 0,
   localparam int ADDR_W  = $clog2(NUM_CTRL + 2)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       host_valid,
   input  logic                       host_write,
   input  logic [ADDR_W-1:0]          host_addr,
   input  logic [DATA_W-1:0]          host_wdata,
   output logic [DATA_W-1:0]          host_rdata,
   output logic                       host_ready,
   input  logic [NUM_CTRL-1:0]        xfer_done,
   output logic [NUM_CTRL-1:0]        xfer_start,
   output logic [NUM_CTRL*DATA_W-1:0] ctrl_q,
   output logic                       svc_req
);
   localparam int RELOAD_ADDR = NUM_CTRL;
   localparam int STAT_ADDR   = NUM_CTRL + 1;
   localparam int STAT_W      = 2 * NUM_CTRL + 1;
   localparam int TMO_BIT     = NUM_CTRL;
   localparam int REJ_LSB     = NUM_CTRL + 1;

   if (NUM_CTRL < 1) begin : g_bad_num
      $error("NUM_CTRL must be at least 1");
   end
   if (STAT_W > DATA_W) begin : g_bad_stat
      $error("DATA_W too narrow for status fields");
   end
   if (TMO_W > DATA_W || TMO_W < 1) begin : g_bad_tmo
      $error("TMO_W must be 1..DATA_W");
   end
   if (REQ_BIT < 0 || REQ_BIT >= DATA_W) begin : g_bad_req
      $error("REQ_BIT outside data word");
   end

   guard_state_e          state_q;
   logic [NUM_CTRL-1:0]   sel_ctrl;
   logic [NUM_CTRL-1:0]   busy_vec;
   logic [NUM_CTRL-1:0]   en_q;
   logic [NUM_CTRL-1:0]   rej_q;
   logic [NUM_CTRL-1:0]   rej_set;
   logic [TMO_W-1:0]      reload_q;
   logic [DATA_W-1:0]     ctrl_r [NUM_CTRL];
   logic [DATA_W-1:0]     rd_mux;
   logic [STAT_W-1:0]     stat_vec;
   logic                  busy_sel, en_sel;
   logic                  in_wait, tmo_zero;
   logic                  stall_start, reject, tmo_fire, cancel;
   logic                  do_access, wr_acc;
   logic                  wr_reload, wr_stat;
   logic                  tmo_q;

   // ---- address decode of the control registers
   for (genvar i = 0; i < NUM_CTRL; i++) begin : g_sel
      assign sel_ctrl[i] = (host_addr == ADDR_W'(i));
   end
   assign busy_sel = |(sel_ctrl & busy_vec);
   assign en_sel   = |(sel_ctrl & en_q);

   // ---- access control
   assign in_wait     = (state_q == GS_WAIT);
   assign stall_start = !in_wait && host_valid && busy_sel && en_sel;
   assign reject      = !in_wait && host_valid && busy_sel && !en_sel;
   assign tmo_fire    = in_wait && busy_sel && tmo_zero;
   assign cancel      = reject || tmo_fire;

   always_comb begin
      if (in_wait) host_ready = !busy_sel || tmo_zero;
      else         host_ready = host_valid && !stall_start;
   end

   assign do_access = host_valid && host_ready && !cancel;
   assign wr_acc    = do_access && host_write;
   assign wr_reload = wr_acc && (host_addr == ADDR_W'(RELOAD_ADDR));
   assign wr_stat   = wr_acc && (host_addr == ADDR_W'(STAT_ADDR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         state_q <= GS_IDLE;
      else if (stall_start)               state_q <= GS_WAIT;
      else if (in_wait && host_ready)     state_q <= GS_IDLE;
   end

   sg_timer #(.TMO_W(TMO_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (stall_start),
      .dec    (in_wait && busy_sel && !tmo_zero),
      .reload (reload_q),
      .zero   (tmo_zero)
   );

   // ---- per control register: storage, transfer tracking, reject flag
   for (genvar i = 0; i < NUM_CTRL; i++) begin : g_ctrl
      logic wr_here;
      assign wr_here       = wr_acc && sel_ctrl[i];
      assign xfer_start[i] = wr_here && host_wdata[REQ_BIT];
      assign rej_set[i]    = reject && sel_ctrl[i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       ctrl_r[i] <= '0;
         else if (wr_here) ctrl_r[i] <= host_wdata;
      end
      assign ctrl_q[i*DATA_W +: DATA_W] = ctrl_r[i];

      sg_pending u_pend (
         .clk   (clk),
         .rst_n (rst_n),
         .start (xfer_start[i]),
         .done  (xfer_done[i]),
         .busy  (busy_vec[i])
      );

      sg_w1c_flag u_rej (
         .clk   (clk),
         .rst_n (rst_n),
         .set   (rej_set[i]),
         .clr   (wr_stat && host_wdata[REJ_LSB + i]),
         .q     (rej_q[i])
      );
   end

   sg_w1c_flag u_tmo (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (tmo_fire),
      .clr   (wr_stat && host_wdata[TMO_BIT]),
      .q     (tmo_q)
   );
   assign svc_req = tmo_q;

   // ---- reload and enable storage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_q <= '0;
         en_q     <= '0;
      end else begin
         if (wr_reload) reload_q <= host_wdata[TMO_W-1:0];
         if (wr_stat)   en_q     <= host_wdata[NUM_CTRL-1:0];
      end
   end

   // ---- read path
   assign stat_vec = {rej_q, tmo_q, en_q};

   always_comb begin
      rd_mux = '0;
      for (int i = 0; i < NUM_CTRL; i++) begin
         if (sel_ctrl[i]) rd_mux = ctrl_r[i];
      end
      if (host_addr == ADDR_W'(RELOAD_ADDR)) rd_mux = DATA_W'(reload_q);
      if (host_addr == ADDR_W'(STAT_ADDR))   rd_mux = DATA_W'(stat_vec);
   end

   assign host_rdata = (do_access && !host_write) ? rd_mux : '0;
endmodule

// File: rtl/sg_guard_chk.sv
module sg_guard_chk #(
   parameter int NUM_CTRL = 2,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                host_valid,
   input logic                host_write,
   input logic [ADDR_W-1:0]   host_addr,
   input logic [DATA_W-1:0]   host_wdata,
   input logic [DATA_W-1:0]   host_rdata,
   input logic                host_ready,
   input logic [NUM_CTRL-1:0] xfer_start,
   input logic                svc_req,
   input logic                in_wait,
   input logic                busy_sel,
   input logic                tmo_zero,
   input logic                cancel
);
   // R4
   wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_wait && busy_sel && !tmo_zero |-> !host_ready);

   // R3
   free_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_wait && !busy_sel |-> host_ready && !cancel);

   // R5
   svc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      svc_req && !(host_valid && host_ready && host_write &&
                   host_addr == ADDR_W'(NUM_CTRL + 1) && host_wdata[NUM_CTRL])
      |=> svc_req);

   // R6
   cancel_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cancel |-> host_rdata == '0 && host_ready);

   // R2
   start_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      |xfer_start |-> host_valid && host_ready && host_write && !cancel);
endmodule

bind regaccess_stall_guard sg_guard_chk #(
   .NUM_CTRL (NUM_CTRL),
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_valid (host_valid),
   .host_write (host_write),
   .host_addr  (host_addr),
   .host_wdata (host_wdata),
   .host_rdata (host_rdata),
   .host_ready (host_ready),
   .xfer_start (xfer_start),
   .svc_req    (svc_req),
   .in_wait    (in_wait),
   .busy_sel   (busy_sel),
   .tmo_zero   (tmo_zero),
   .cancel     (cancel)
);

// File: tb/sim_regaccess_stall_guard.sv
`timescale 1ns/1ps
module sim_regaccess_stall_guard;
   localparam int NC = 2;
   localparam int DW = 32;
   localparam int AW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          host_valid = 1'b0;
   logic          host_write = 1'b0;
   logic [AW-1:0] host_addr = '0;
   logic [DW-1:0] host_wdata = '0;
   logic [DW-1:0] host_rdata;
   logic          host_ready;
   logic [NC-1:0] xfer_done = '0;
   logic [NC-1:0] xfer_start;
   logic [NC*DW-1:0] ctrl_q;
   logic          svc_req;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   regaccess_stall_guard #(.NUM_CTRL(NC), .DATA_W(DW), .TMO_W(32), .REQ_BIT(0)) u0 (
      .clk, .rst_n, .host_valid, .host_write, .host_addr, .host_wdata,
      .host_rdata, .host_ready, .xfer_done, .xfer_start, .ctrl_q, .svc_req
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic acc(input int addr, input bit we, input logic [DW-1:0] wd,
                      output logic [DW-1:0] rd, output int lat,
                      output logic [NC-1:0] xs);
      @(negedge clk);
      host_valid = 1'b1; host_write = we; host_addr = AW'(addr); host_wdata = wd;
      lat = 0;
      #1;
      while (!host_ready) begin
         @(negedge clk); #1; lat++;
      end
      rd = host_rdata; xs = xfer_start;
      @(posedge clk); #1;
      host_valid = 1'b0; host_write = 1'b0;
   endtask

   task automatic done_after(input int idx, input int k);
      @(negedge clk);
      repeat (k) @(negedge clk);
      xfer_done[idx] = 1'b1;
      @(negedge clk);
      xfer_done[idx] = 1'b0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin : main
      logic [DW-1:0] rd, v, nv;
      logic [NC-1:0] xs;
      int lat;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R9 reset values
      chk(svc_req == 1'b0, "R9 svc", svc_req, 0);
      for (int a = 0; a < 4; a++) begin
         acc(a, 0, '0, rd, lat, xs);
         chk(rd == 0 && lat == 0, "R9 reset read", rd, 0);
      end

      // R1 free access
      acc(1, 1, 32'h1234_5670, rd, lat, xs);
      chk(lat == 0 && xs == 0, "R1 free write", lat, 0);
      acc(1, 0, '0, rd, lat, xs);
      chk(rd == 32'h1234_5670 && lat == 0, "R1 readback", rd, 32'h1234_5670);
      chk(ctrl_q[DW +: DW] == 32'h1234_5670, "R1 ctrl_q", ctrl_q[DW +: DW], 32'h1234_5670);

      // R10 status / reload layout
      acc(2, 1, 32'h0000_0007, rd, lat, xs);
      acc(2, 0, '0, rd, lat, xs);
      chk(rd == 7, "R10 reload readback", rd, 7);
      acc(3, 1, 32'h3, rd, lat, xs);
      acc(3, 0, '0, rd, lat, xs);
      chk(rd == 3, "R10 enables", rd, 3);

      // R3 R4 R7 R8 sweep over both registers
      for (int t = 0; t < NC; t++) begin
         for (int r = 0; r < 4; r++) begin
            for (int k = 1; k < 6; k++) begin
               bit wr_op;
               bit timed;
               wr_op = (k % 2) == 0;
               timed = k > r + 1;
               acc(2, 1, DW'(r), rd, lat, xs);
               v  = {8'hA0, 8'(t), 8'(r), 8'(k)} | 32'h1;
               nv = v ^ 32'h00FF_FF01;
               acc(t, 1, v, rd, lat, xs);
               // R2 start pulse
               chk(xs == NC'(1 << t), "R2 start pulse", xs, 1 << t);
               fork
                  acc(t, wr_op, nv, rd, lat, xs);
                  done_after(t, k);
               join
               if (!timed) begin
                  chk(lat == k, "R3 R7 latency", lat, k);
                  if (!wr_op) chk(rd == v, "R3 stalled read", rd, v);
                  acc(t, 0, '0, rd, lat, xs);
                  chk(rd == (wr_op ? nv : v), "R3 stalled write", rd, wr_op ? nv : v);
                  chk(svc_req == 1'b0, "R7 no timeout", svc_req, 0);
               end else begin
                  chk(lat == r + 1, (r == 0) ? "R8 zero reload" : "R4 timeout latency",
                      lat, r + 1);
                  if (!wr_op) chk(rd == 0, "R4 cancelled read", rd, 0);
                  acc(t, 0, '0, rd, lat, xs);
                  chk(rd == v, "R4 register unchanged", rd, v);
                  // R5 sticky through further accesses
                  acc(3, 0, '0, rd, lat, xs);
                  chk(rd == 32'h7 && svc_req, "R5 sticky", rd, 7);
                  acc(3, 1, 32'h7, rd, lat, xs);
                  acc(3, 0, '0, rd, lat, xs);
                  chk(rd == 32'h3 && !svc_req, "R5 cleared", rd, 3);
               end
            end
         end
      end

      // R6 reject with stalling disabled
      acc(3, 1, 32'h0, rd, lat, xs);
      for (int t = 0; t < NC; t++) begin
         v = 32'hC0DE_0001 + DW'(t << 8);
         acc(t, 1, v, rd, lat, xs);
         acc(t, 0, '0, rd, lat, xs);
         chk(lat == 0 && rd == 0, "R6 rejected read", rd, 0);
         acc(t, 1, 32'hFFFF_FFFF, rd, lat, xs);
         chk(lat == 0 && xs == 0, "R6 rejected write no start", xs, 0);
         acc(3, 0, '0, rd, lat, xs);
         chk(rd == DW'(1 << (3 + t)) && !svc_req, "R6 reject flag", rd, 1 << (3 + t));
         done_after(t, 1);
         acc(t, 0, '0, rd, lat, xs);
         chk(rd == v, "R6 register unchanged", rd, v);
         acc(3, 1, DW'(1 << (3 + t)), rd, lat, xs);
         acc(3, 0, '0, rd, lat, xs);
         chk(rd == 0, "R10 reject flag cleared", rd, 0);
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule